// File: doc/BRIEF.md
# Host Data Port Handshake and Request Controller

This block sits between an external host processor and an internal processor and carries data words both ways. Host-to-internal traffic passes through two register stages: a host-side staging register written by the host and an internal-side holding register read by the internal processor. Internal-to-host traffic uses a single host receive register, loaded by the internal side and read by the host. The host sees a small register map: a control/status word, a data window and a command word.

The host is told when to act through one active-low, registered request pin, `hreq_n`. Three conditions can raise it: data waiting for the host, room in the staging register, and the whole transmit pipeline drained. Each has its own enable bit. When DMA mode is on, the receive enable stops acting as a mask and picks the direction instead, so the pin paces an external DMA engine. A command word can flush either path. A host reset flushes both paths and keeps the control bits. Hardware reset (`rst_n`) and software reset (`sw_rst`) clear everything.

The transmit pipeline is a four-state machine:
- TX_IDLE: both stages empty.
- TX_HOST: only the staging register holds data.
- TX_INT: only the holding register holds data.
- TX_BOTH: both stages hold data.

Its transitions are:
- TX_IDLE→TX_HOST on an accepted host write.
- TX_HOST→TX_INT on the following clock, when the word moves down.
- TX_INT→TX_IDLE on an internal read.
- TX_INT→TX_BOTH on a host write.
- TX_INT→TX_HOST on a host write and an internal read in the same cycle.
- TX_BOTH→TX_HOST on an internal read.
- Any state→TX_IDLE on a flush.

The receive register is a two-state machine. RX_EMPTY→RX_FULL on an internal write. RX_FULL→RX_EMPTY on a host data read or a flush. The request pin comes from a two-state machine: REQ_IDLE (pin high) and REQ_ACTIVE (pin low). Each clock it moves to REQ_ACTIVE when an enabled condition holds and to REQ_IDLE when none does.

Top module: `hostport_ctl`

## Requirements
- R1: Register map: address 0 is control/status, with bit 0 `rx_full`, bit 1 `tx_empty`, bit 2 `tx_ready`, bit 3 `en_rx`, bit 4 `en_tx`, bit 5 `en_ready`, bit 6 `dma_mode`, and all other bits reading 0. Address 1 is the data window. Address 2 is the command word, where bit 0 = 1 means initialise. Host writes to bits 0–2 of address 0 have no effect.
- R2: A host write to address 1 that is accepted clears `tx_empty` at the next edge. A write while `tx_empty`=0 is ignored. `tx_empty` reads correctly whatever the enables are.
- R3: A word in the staging register moves to the holding register on the next clock edge, since the holding register is empty in that state. `tx_empty` then returns to 1 and `i_rx_full` becomes 1.
- R4: `tx_ready` is 1 exactly when both transmit stages are empty.
- R5: An internal write loads the host receive register only when `rx_full`=0, and sets `rx_full`. It is ignored when `rx_full`=1. A host read of address 1 clears `rx_full`.
- R6: An internal read (`i_rd`) empties the holding register.
- R7: Outside DMA mode, `hreq_n` is low one clock after (`en_rx`&`rx_full`) | (`en_tx`&`tx_empty`) | (`en_ready`&`tx_ready`) holds, and high one clock after it does not.
- R8: In DMA mode the request condition is `rx_full` when `en_rx`=1 and `tx_empty` when `en_rx`=0. `en_tx` and `en_ready` have no effect.
- R9: Writing the initialise command with `en_tx`=1 flushes the transmit path, so `tx_ready`=1. With `en_rx`=1 it empties the host receive register. With both enables 0 it has no effect. The control bits are unchanged.
- R10: A `host_rst` pulse empties both paths and leaves the control bits unchanged.
- R11: Hardware reset and `sw_rst` clear the control bits, empty both paths and drive `hreq_n` high.
- R12: A host data write and an internal read in the same cycle in state TX_INT both take effect: TX_HOST follows, then TX_INT holding the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset |
| host_rst | input | 1 | Synchronous host-side reset of both data paths |
| h_addr | input | 2 | Host register address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (data window read has a side effect) |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data, combinational from `h_addr` |
| hreq_n | output | 1 | Registered host request, active low |
| i_rd | input | 1 | Internal read of the holding register |
| i_rdata | output | DW | Holding register contents |
| i_rx_full | output | 1 | Holding register holds a word |
| i_wr | input | 1 | Internal write to the host receive register |
| i_wdata | input | DW | Internal write data |
| i_wr_ready | output | 1 | Host receive register can accept a word |

## Verification
Two pairs of functions can fall in the same cycle. In TX_INT, a host data write and an internal read can arrive together. The bench drives both strobes on one edge and expects TX_HOST, with `tx_empty`=0 and `i_rx_full`=0, followed one edge later by the new word in the holding register. With the host receive register full, a host data read and an internal write can also coincide. The bench expects the register to end empty and the old word to remain, because the write is judged against the full state. The request pin is swept over every enable combination against three stable transmit states and both receive states, and each expected level is computed from R7 and R8.

// File: rtl/hp_pkg.sv
package hp_pkg;
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_HOST = 2'd1,
        TX_INT  = 2'd2,
        TX_BOTH = 2'd3
    } tx_state_t;

    typedef enum logic {
        RX_EMPTY = 1'b0,
        RX_FULL  = 1'b1
    } rx_state_t;

    typedef enum logic {
        REQ_IDLE   = 1'b0,
        REQ_ACTIVE = 1'b1
    } req_state_t;

    typedef struct packed {
        logic dma_mode;
        logic en_ready;
        logic en_tx;
        logic en_rx;
    } ctrl_t;

    localparam int          BIT_RXF   = 0;
    localparam int          BIT_TXE   = 1;
    localparam int          BIT_RDY   = 2;
    localparam int          BIT_CTRL  = 3;
    localparam int          CTRL_W    = 4;
    localparam logic [1:0]  ADDR_CSR  = 2'd0;
    localparam logic [1:0]  ADDR_DATA = 2'd1;
    localparam logic [1:0]  ADDR_CMD  = 2'd2;
endpackage

// File: rtl/hp_tx_path.sv
module hp_tx_path
    import hp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    input  logic          int_rd,
    output logic          tx_empty,
    output logic          tx_ready,
    output logic          int_full,
    output logic [DW-1:0] int_data
);
    tx_state_t     state_q, state_d;
    logic [DW-1:0] stage_q;
    logic [DW-1:0] hold_q;
    logic          accept;
    logic          move;

    assign accept   = host_wr && tx_empty && !clr;
    assign move     = (state_q == TX_HOST) && !clr;
    assign int_data = hold_q;

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = TX_IDLE;
        end else begin
            unique case (state_q)
                TX_IDLE: if (host_wr) state_d = TX_HOST;
                TX_HOST: state_d = TX_INT;
                TX_INT: begin
                    if (host_wr && int_rd) state_d = TX_HOST;
                    else if (host_wr)      state_d = TX_BOTH;
                    else if (int_rd)       state_d = TX_IDLE;
                end
                TX_BOTH: if (int_rd) state_d = TX_HOST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            hold_q  <= '0;
        end else begin
            if (accept) stage_q <= host_wdata;
            if (move)   hold_q  <= stage_q;
        end
    end

    always_comb begin
        unique case (state_q)
            TX_IDLE: begin tx_empty = 1'b1; tx_ready = 1'b1; int_full = 1'b0; end
            TX_HOST: begin tx_empty = 1'b0; tx_ready = 1'b0; int_full = 1'b0; end
            TX_INT:  begin tx_empty = 1'b1; tx_ready = 1'b0; int_full = 1'b1; end
            TX_BOTH: begin tx_empty = 1'b0; tx_ready = 1'b0; int_full = 1'b1; end
        endcase
    end

    assert_write_clears_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && tx_empty && !clr) |=> !tx_empty);
    assert_word_moves_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_HOST && !clr) |=> (int_full && tx_empty && hold_q == $past(stage_q)));
    assert_int_read_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_full && int_rd && !host_wr && !clr) |=> !int_full);
    assert_both_and_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_INT && host_wr && int_rd && !clr) |=> (!tx_empty && !int_full));
endmodule

// File: rtl/hp_rx_path.sv
module hp_rx_path
    import hp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          int_wr,
    input  logic [DW-1:0] int_wdata,
    input  logic          host_rd,
    output logic          rx_full,
    output logic [DW-1:0] host_data
);
    rx_state_t     state_q, state_d;
    logic [DW-1:0] data_q;
    logic          load;

    assign load      = int_wr && (state_q == RX_EMPTY) && !clr;
    assign host_data = data_q;

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = RX_EMPTY;
        end else begin
            unique case (state_q)
                RX_EMPTY: if (int_wr)  state_d = RX_FULL;
                RX_FULL:  if (host_rd) state_d = RX_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    data_q <= '0;
        else if (load) data_q <= int_wdata;
    end

    always_comb begin
        unique case (state_q)
            RX_EMPTY: rx_full = 1'b0;
            RX_FULL:  rx_full = 1'b1;
        endcase
    end

    assert_full_ignores_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && int_wr) |=> $stable(data_q));
    assert_host_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && host_rd) |=> !rx_full);
endmodule

// File: rtl/hp_req.sv
module hp_req
    import hp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sw_rst,
    input  ctrl_t ctrl,
    input  logic  rx_full,
    input  logic  tx_empty,
    input  logic  tx_ready,
    output logic  hreq_n
);
    req_state_t state_q, state_d;
    logic       want;

    always_comb begin
        if (ctrl.dma_mode)
            want = ctrl.en_rx ? rx_full : tx_empty;
        else
            want = (ctrl.en_rx && rx_full) || (ctrl.en_tx && tx_empty)
                || (ctrl.en_ready && tx_ready);
    end

    always_comb begin
        state_d = state_q;
        if (sw_rst) begin
            state_d = REQ_IDLE;
        end else begin
            unique case (state_q)
                REQ_IDLE:   if (want)  state_d = REQ_ACTIVE;
                REQ_ACTIVE: if (!want) state_d = REQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            REQ_IDLE:   hreq_n = 1'b1;
            REQ_ACTIVE: hreq_n = 1'b0;
        endcase
    end

    assert_rx_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.dma_mode && ctrl.en_rx && rx_full && !sw_rst) |=> !hreq_n);
    assert_dma_masks_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.dma_mode && !ctrl.en_rx && !tx_empty && !sw_rst) |=> hreq_n);
endmodule

// File: rtl/hostport_ctl.sv
module hostport_ctl
    import hp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_rst,
    input  logic          host_rst,
    input  logic [1:0]    h_addr,
    input  logic          h_wr,
    input  logic          h_rd,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    output logic          hreq_n,
    input  logic          i_rd,
    output logic [DW-1:0] i_rdata,
    output logic          i_rx_full,
    input  logic          i_wr,
    input  logic [DW-1:0] i_wdata,
    output logic          i_wr_ready
);
    localparam int STAT_W = BIT_CTRL + CTRL_W;

    ctrl_t         ctrl_q;
    logic          csr_wr, data_wr, data_rd, init_cmd;
    logic          tx_clr, rx_clr;
    logic          tx_empty, tx_ready, rx_full;
    logic [DW-1:0] rx_data;
    logic [STAT_W-1:0] stat_word;

    assign csr_wr   = h_wr && (h_addr == ADDR_CSR);
    assign data_wr  = h_wr && (h_addr == ADDR_DATA);
    assign data_rd  = h_rd && (h_addr == ADDR_DATA);
    assign init_cmd = h_wr && (h_addr == ADDR_CMD) && h_wdata[0];
    assign tx_clr   = sw_rst || host_rst || (init_cmd && ctrl_q.en_tx);
    assign rx_clr   = sw_rst || host_rst || (init_cmd && ctrl_q.en_rx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (sw_rst) ctrl_q <= '0;
        else if (csr_wr) ctrl_q <= h_wdata[BIT_CTRL +: CTRL_W];
    end

    hp_tx_path #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .host_wr(data_wr), .host_wdata(h_wdata), .int_rd(i_rd),
        .tx_empty(tx_empty), .tx_ready(tx_ready),
        .int_full(i_rx_full), .int_data(i_rdata)
    );

    hp_rx_path #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .int_wr(i_wr), .int_wdata(i_wdata), .host_rd(data_rd),
        .rx_full(rx_full), .host_data(rx_data)
    );

    hp_req u_req (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .ctrl(ctrl_q),
        .rx_full(rx_full), .tx_empty(tx_empty), .tx_ready(tx_ready),
        .hreq_n(hreq_n)
    );

    assign i_wr_ready = !rx_full;

    always_comb begin
        stat_word          = '0;
        stat_word[BIT_RXF] = rx_full;
        stat_word[BIT_TXE] = tx_empty;
        stat_word[BIT_RDY] = tx_ready;
        stat_word[BIT_CTRL +: CTRL_W] = ctrl_q;
    end

    always_comb begin
        h_rdata = '0;
        case (h_addr)
            ADDR_CSR:  h_rdata[STAT_W-1:0] = stat_word;
            ADDR_DATA: h_rdata = rx_data;
            default:   h_rdata = '0;
        endcase
    end

    assert_ready_needs_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (tx_empty && !i_rx_full));
    assert_init_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (init_cmd && ctrl_q.en_tx && !sw_rst) |=> tx_ready);
    assert_host_reset_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rst && !sw_rst && !csr_wr) |=> ($stable(ctrl_q) && tx_ready && !rx_full));
    assert_sw_reset_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (ctrl_q == '0 && tx_ready && !rx_full && hreq_n));
endmodule

// File: tb/test_hostport_ctl.sv
module test_hostport_ctl;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_rst = 1'b0, host_rst = 1'b0;
    logic [1:0]    h_addr = 2'd0;
    logic          h_wr = 1'b0, h_rd = 1'b0;
    logic [DW-1:0] h_wdata = '0;
    logic [DW-1:0] h_rdata;
    logic          hreq_n;
    logic          i_rd = 1'b0;
    logic [DW-1:0] i_rdata;
    logic          i_rx_full;
    logic          i_wr = 1'b0;
    logic [DW-1:0] i_wdata = '0;
    logic          i_wr_ready;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    hostport_ctl #(.DW(DW)) i_hostport_ctl (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .host_rst(host_rst),
        .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .hreq_n(hreq_n), .i_rd(i_rd), .i_rdata(i_rdata),
        .i_rx_full(i_rx_full), .i_wr(i_wr), .i_wdata(i_wdata),
        .i_wr_ready(i_wr_ready)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [DW-1:0] d);
        h_addr = a; h_wdata = d; h_wr = 1'b1;
        @(negedge clk);
        h_wr = 1'b0; h_addr = 2'd0;
    endtask

    task automatic hread_data(output int v);
        h_addr = 2'd1; #1 v = int'(h_rdata); h_rd = 1'b1;
        @(negedge clk);
        h_rd = 1'b0; h_addr = 2'd0;
    endtask

    task automatic csr(output int v);
        h_addr = 2'd0; #1 v = int'(h_rdata);
    endtask

    task automatic iwrite(input logic [DW-1:0] d);
        i_wdata = d; i_wr = 1'b1;
        @(negedge clk);
        i_wr = 1'b0;
    endtask

    task automatic iread();
        i_rd = 1'b1;
        @(negedge clk);
        i_rd = 1'b0;
    endtask

    task automatic pulse_sw();
        sw_rst = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0;
    endtask

    function automatic int stat(input int c, input int rdy, input int txe, input int rxf);
        return (c << 3) | (rdy << 2) | (txe << 1) | rxf;
    endfunction

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int v;
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R11 / R1: reset state
        csr(v); chk(v, stat(0, 1, 1, 0), "R11 reset status");
        chk(int'(hreq_n), 1, "R11 reset hreq_n");
        chk(int'(i_rx_full), 0, "R11 reset holding empty");

        // R1: status bits read-only, control bits writable
        hwrite(2'd0, 8'h07);
        csr(v); chk(v, stat(0, 1, 1, 0), "R1 status bits read-only");
        hwrite(2'd0, 8'h78);
        csr(v); chk(v, stat(15, 1, 1, 0), "R1 control bits");

        // R7: request timing (en_tx with tx_empty)
        pulse_sw();
        hwrite(2'd0, 8'h10);
        chk(int'(hreq_n), 1, "R7 request not yet registered");
        tick();
        chk(int'(hreq_n), 0, "R7 request one clock later");

        // R2 / R3: write and move timing
        pulse_sw();
        hwrite(2'd1, 8'h3C);
        csr(v); chk(v & 2, 0, "R2 write clears tx_empty");
        chk(int'(i_rx_full), 0, "R3 holding still empty");
        tick();
        csr(v); chk(v, stat(0, 0, 1, 0), "R3 tx_empty returns");
        chk(int'(i_rx_full), 1, "R3 holding full");
        chk(int'(i_rdata), 'h3C, "R3 holding data");

        // R2: write while full ignored; R6 / R4 after internal read
        pulse_sw();
        hwrite(2'd1, 8'hA1);
        hwrite(2'd1, 8'hB2);
        tick();
        chk(int'(i_rdata), 'hA1, "R2 ignored write keeps first word");
        csr(v); chk(v, stat(0, 0, 1, 0), "R2 staging empty after ignored write");
        iread();
        chk(int'(i_rx_full), 0, "R6 internal read empties");
        csr(v); chk(v, stat(0, 1, 1, 0), "R4 ready when both empty");

        // R12: host write and internal read together in TX_INT
        pulse_sw();
        hwrite(2'd1, 8'h11);
        tick();
        h_addr = 2'd1; h_wdata = 8'h22; h_wr = 1'b1; i_rd = 1'b1;
        @(negedge clk);
        h_wr = 1'b0; i_rd = 1'b0; h_addr = 2'd0;
        csr(v); chk(v, stat(0, 0, 0, 0), "R12 staging holds new word");
        chk(int'(i_rx_full), 0, "R12 holding emptied");
        tick();
        chk(int'(i_rdata), 'h22, "R12 new word moved");
        chk(int'(i_rx_full), 1, "R12 holding full again");

        // R5: receive register
        pulse_sw();
        iwrite(8'h33);
        csr(v); chk(v, stat(0, 1, 1, 1), "R5 internal write sets rx_full");
        chk(int'(i_wr_ready), 0, "R5 write ready low when full");
        iwrite(8'h44);
        h_addr = 2'd1; #1 chk(int'(h_rdata), 'h33, "R5 write ignored when full");
        h_rd = 1'b1; i_wdata = 8'h55; i_wr = 1'b1;
        @(negedge clk);
        h_rd = 1'b0; i_wr = 1'b0;
        csr(v); chk(v, stat(0, 1, 1, 0), "R5 host read clears rx_full");
        h_addr = 2'd1; #1 chk(int'(h_rdata), 'h33, "R5 coincident write ignored");
        h_addr = 2'd0;
        iwrite(8'h66);
        hread_data(v); chk(v, 'h66, "R5 host reads word");
        csr(v); chk(v & 1, 0, "R5 cleared after read");

        // R9: initialise command
        pulse_sw();
        hwrite(2'd0, 8'h10);
        hwrite(2'd1, 8'h01); tick(); hwrite(2'd1, 8'h02);
        iwrite(8'h77);
        hwrite(2'd2, 8'h01);
        csr(v); chk(v, stat(2, 1, 1, 1), "R9 init flushes transmit only");
        hwrite(2'd0, 8'h08);
        hwrite(2'd2, 8'h01);
        csr(v); chk(v, stat(1, 1, 1, 0), "R9 init empties receive");
        hwrite(2'd0, 8'h00);
        hwrite(2'd1, 8'h03); tick();
        iwrite(8'h78);
        hwrite(2'd2, 8'h01);
        csr(v); chk(v, stat(0, 0, 1, 1), "R9 init without enables no effect");

        // R10: host reset
        pulse_sw();
        hwrite(2'd0, 8'h38);
        hwrite(2'd1, 8'h04); tick(); hwrite(2'd1, 8'h05);
        iwrite(8'h79);
        host_rst = 1'b1; @(negedge clk); host_rst = 1'b0;
        csr(v); chk(v, stat(7, 1, 1, 0), "R10 host reset keeps control");

        // R11: software reset and hardware reset
        hwrite(2'd1, 8'h06);
        iwrite(8'h7A);
        pulse_sw();
        csr(v); chk(v, stat(0, 1, 1, 0), "R11 sw reset status");
        chk(int'(hreq_n), 1, "R11 sw reset hreq_n");
        hwrite(2'd0, 8'h18);
        iwrite(8'h7B);
        tick();
        rst_n = 1'b0; #1;
        csr(v); chk(v, stat(0, 1, 1, 0), "R11 hw reset status");
        chk(int'(hreq_n), 1, "R11 hw reset hreq_n");
        tick(); rst_n = 1'b1; tick();

        // R7 / R8: sweep enables against stable status states
        for (int c = 0; c < 16; c++) begin
            for (int rx = 0; rx < 2; rx++) begin
                for (int tx = 0; tx < 3; tx++) begin
                    int txe, rdy, req, rr, rt, ry, dm;
                    pulse_sw();
                    hwrite(2'd0, 8'(c << 3));
                    if (rx == 1) iwrite(8'h5A);
                    if (tx >= 1) begin hwrite(2'd1, 8'h10); tick(); end
                    if (tx == 2) hwrite(2'd1, 8'h20);
                    tick(); tick();
                    txe = (tx == 2) ? 0 : 1;
                    rdy = (tx == 0) ? 1 : 0;
                    rr = c & 1; rt = (c >> 1) & 1; ry = (c >> 2) & 1; dm = (c >> 3) & 1;
                    if (dm == 1) req = (rr == 1) ? rx : txe;
                    else         req = (rr & rx) | (rt & txe) | (ry & rdy);
                    csr(v); chk(v, stat(c, rdy, txe, rx), "R1 R4 sweep status");
                    if (dm == 1) chk(int'(hreq_n), 1 - req, "R8 dma request");
                    else         chk(int'(hreq_n), 1 - req, "R7 request");
                end
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule